// File: doc/BRIEF.md
# Debug Abstract Command Engine

This block is the register-level front end through which a debugger issues abstract commands to one hart. The debugger places arguments in a bank of 32-bit data words and then writes a command word. The engine decodes the register number in the command into a CSR, GPR or FPR access and checks that the command is supported. It then issues one request on a simple request/response port toward the hart named by the hart-select input. For a read, the returned value goes back into the data words. If the command asks for it, one program-buffer run is chained after the access.

A busy flag is set while a command is in flight. Every failure is recorded in a sticky three-bit error code in the control/status word. No failure is reported as a bus error. The debugger learns which commands are supported by issuing them and then reading that code. The data bank holds three arguments of XLEN bits each. The least significant word of each value sits in the lowest-numbered data word.

Top module: `abscmd_engine`

## Requirements
- R1: After reset the control/status word (address 0x10) reads busy (bit 12) = 0, error (bits 10:8) = 0 and data count (bits 3:0) = 3*XLEN/32, and every data word reads 0.
- R2: While not busy, a write to data address i (0 to 3*XLEN/32-1) stores the value, and a read of that address returns it. The command address 0x11 reads as 0.
- R3: A supported transfer command written to 0x11 sets busy from the next cycle. It raises exactly one hart request, with index, kind and write data held until the response, and tagged with the hart-select value captured at the write. Busy clears when the command completes.
- R4: Register number decode uses bits 15:0. 0x0000-0x0fff gives kind 0 (CSR) with index = low 12 bits. 0x1000-0x101f gives kind 1 (GPR) with index = low 5 bits. 0x1020-0x103f gives kind 2 (FPR) with index = low 5 bits when FPR support is enabled. Any other number gives error 2 and no request.
- R5: Command layout: bits 31:24 = type (only 0 is supported), bits 22:20 = size (must equal log2(XLEN/8)), bit 18 = post-execute, bit 17 = transfer, bit 16 = write. A wrong type, or a wrong size when transfer is 1, gives error 2 and no request.
- R6: A write access sends data words 0 to XLEN/32-1 as the value, least significant word in word 0. A read access stores the response in those same words, lowest word least significant, and leaves the other data words unchanged.
- R7: A supported command issued while the hart-halted input is 0 gives error 4 and starts nothing.
- R8: With post-execute set, one program-buffer run (pb_run held until pb_done) follows a successful access. With transfer 0 the run starts without any access. An exception reported with pb_done gives error 3.
- R9: An error response from the hart gives error 3, skips the program-buffer run, and leaves the data words unchanged.
- R10: While busy, a write to the command or to any data word is dropped, the running command completes normally, and the error becomes 1 if it was 0.
- R11: A nonzero error is sticky: a command written while it is nonzero is ignored. Writing 1s to bits 10:8 of 0x10 clears the matching error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| hartsel | input | HART_W | Index of the hart the next command targets |
| hart_halted | input | 1 | Selected hart is halted |
| hreq_valid | output | 1 | Register access request pending |
| hreq_write | output | 1 | Request is a write |
| hreq_kind | output | 2 | 0 CSR, 1 GPR, 2 FPR |
| hreq_index | output | 12 | Register index within its kind |
| hreq_hart | output | HART_W | Hart index captured at command write |
| hreq_wdata | output | XLEN | Value for a write access |
| hrsp_valid | input | 1 | One-cycle response strobe |
| hrsp_err | input | 1 | Access failed |
| hrsp_rdata | input | XLEN | Value returned for a read access |
| pb_run | output | 1 | Program-buffer run requested |
| pb_done | input | 1 | Program-buffer run finished |
| pb_exception | input | 1 | Run ended in an exception, valid with pb_done |

## Verification
The assertions assume the hart side behaves well. hrsp_valid is a single-cycle strobe that arrives only while hreq_valid is high, and pb_done arrives only while pb_run is high. The bench drives both through small behavioural models that respond after a programmable delay and only to a pending request. Random commands are drawn only from supported register numbers, and no random command is issued until the previous one reads back idle. Fault cases such as reserved numbers, a running hart, busy writes and error responses are applied as directed tests. Each of them ends with an explicit error clear.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

    typedef enum logic [1:0] {
        KIND_CSR  = 2'd0,
        KIND_GPR  = 2'd1,
        KIND_FPR  = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_PROGBUF = 2'd2
    } eng_state_e;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BUSY  = 3'd1;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
    localparam logic [2:0] ERR_EXC   = 3'd3;
    localparam logic [2:0] ERR_HALT  = 3'd4;

    localparam int CS_BUSY_BIT = 12;
    localparam int CS_ERR_LSB  = 8;

endpackage

// File: rtl/abscmd_decode.sv
module abscmd_decode
    import abscmd_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_FPR = 1'b1
) (
    input  logic [31:0] cmd,
    input  logic        halted,
    output logic [2:0]  err,
    output reg_kind_e   kind,
    output logic [11:0] index,
    output logic        is_write,
    output logic        do_xfer,
    output logic        do_post
);
    localparam logic [2:0] SIZE_CODE = 3'($clog2(XLEN / 8));

    logic [7:0]  cmd_type;
    logic [2:0]  size;
    logic [15:0] regno;

    always_comb begin
        cmd_type = cmd[31:24];
        size     = cmd[22:20];
        do_post  = cmd[18];
        do_xfer  = cmd[17];
        is_write = cmd[16];
        regno    = cmd[15:0];

        if (regno[15:12] == 4'h0) begin
            kind  = KIND_CSR;
            index = regno[11:0];
        end else if (regno[15:5] == 11'h080) begin
            kind  = KIND_GPR;
            index = {7'd0, regno[4:0]};
        end else if (HAS_FPR && regno[15:5] == 11'h081) begin
            kind  = KIND_FPR;
            index = {7'd0, regno[4:0]};
        end else begin
            kind  = KIND_NONE;
            index = 12'd0;
        end

        if (cmd_type != 8'd0) begin
            err = ERR_UNSUP;
        end else if (do_xfer && (size != SIZE_CODE || kind == KIND_NONE)) begin
            err = ERR_UNSUP;
        end else if (!halted) begin
            err = ERR_HALT;
        end else begin
            err = ERR_NONE;
        end
    end
endmodule

// File: rtl/abscmd_datafile.sv
module abscmd_datafile #(
    parameter int NWORDS = 6,
    parameter int RWORDS = 2,
    parameter int IDX_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [31:0]           wr_data,
    input  logic                  res_en,
    input  logic [RWORDS*32-1:0]  res_data,
    output logic [NWORDS*32-1:0]  words
);
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [31:0] word_d, word_q;

        if (g < RWORDS) begin : g_result
            always_comb begin
                word_d = word_q;
                if (res_en) begin
                    word_d = res_data[g*32 +: 32];
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    word_d = wr_data;
                end
            end
        end else begin : g_plain
            always_comb begin
                word_d = word_q;
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    word_d = wr_data;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign words[g*32 +: 32] = word_q;
    end
endmodule

// File: rtl/abscmd_engine.sv
module abscmd_engine
    import abscmd_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int HART_W  = 10,
    parameter int ADDR_W  = 5,
    parameter bit HAS_FPR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [HART_W-1:0] hartsel,
    input  logic              hart_halted,
    output logic              hreq_valid,
    output logic              hreq_write,
    output logic [1:0]        hreq_kind,
    output logic [11:0]       hreq_index,
    output logic [HART_W-1:0] hreq_hart,
    output logic [XLEN-1:0]   hreq_wdata,
    input  logic              hrsp_valid,
    input  logic              hrsp_err,
    input  logic [XLEN-1:0]   hrsp_rdata,
    output logic              pb_run,
    input  logic              pb_done,
    input  logic              pb_exception
);
    localparam int WPA    = XLEN / 32;
    localparam int NDATA  = 3 * WPA;
    localparam logic [ADDR_W-1:0] ADDR_CS  = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] ADDR_CMD = ADDR_W'(17);

    typedef struct packed {
        eng_state_e        st;
        logic [2:0]        err;
        reg_kind_e         kind;
        logic [11:0]       idx;
        logic              wr;
        logic              post;
        logic [HART_W-1:0] hart;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic [2:0]           dec_err;
    reg_kind_e            dec_kind;
    logic [11:0]          dec_index;
    logic                 dec_write, dec_xfer, dec_post;
    logic                 busy;
    logic                 wr_cs, wr_cmd, wr_data;
    logic                 res_en;
    logic [NDATA*32-1:0]  words;
    logic [2:0]           err_cur;

    abscmd_decode #(.XLEN(XLEN), .HAS_FPR(HAS_FPR)) u_decode (
        .cmd      (bus_wdata),
        .halted   (hart_halted),
        .err      (dec_err),
        .kind     (dec_kind),
        .index    (dec_index),
        .is_write (dec_write),
        .do_xfer  (dec_xfer),
        .do_post  (dec_post)
    );

    abscmd_datafile #(.NWORDS(NDATA), .RWORDS(WPA), .IDX_W(ADDR_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_data && !busy),
        .wr_idx   (bus_addr),
        .wr_data  (bus_wdata),
        .res_en   (res_en),
        .res_data (hrsp_rdata),
        .words    (words)
    );

    always_comb begin
        busy    = (cur_q.st != ST_IDLE);
        wr_cs   = bus_we && bus_addr == ADDR_CS;
        wr_cmd  = bus_we && bus_addr == ADDR_CMD;
        wr_data = bus_we && bus_addr < ADDR_W'(NDATA);
        res_en  = (cur_q.st == ST_ACCESS) && hrsp_valid && !hrsp_err && !cur_q.wr;

        nxt_d = cur_q;
        if (wr_cs) begin
            nxt_d.err = cur_q.err & ~bus_wdata[CS_ERR_LSB +: 3];
        end

        unique case (cur_q.st)
            ST_IDLE: begin
                if (wr_cmd && cur_q.err == ERR_NONE) begin
                    if (dec_err != ERR_NONE) begin
                        nxt_d.err = dec_err;
                    end else begin
                        nxt_d.kind = dec_kind;
                        nxt_d.idx  = dec_index;
                        nxt_d.wr   = dec_write;
                        nxt_d.post = dec_post;
                        nxt_d.hart = hartsel;
                        if (dec_xfer) begin
                            nxt_d.st = ST_ACCESS;
                        end else if (dec_post) begin
                            nxt_d.st = ST_PROGBUF;
                        end
                    end
                end
            end
            ST_ACCESS: begin
                if (hrsp_valid) begin
                    if (hrsp_err) begin
                        nxt_d.err = ERR_EXC;
                        nxt_d.st  = ST_IDLE;
                    end else begin
                        nxt_d.st = cur_q.post ? ST_PROGBUF : ST_IDLE;
                    end
                end
            end
            ST_PROGBUF: begin
                if (pb_done) begin
                    if (pb_exception) begin
                        nxt_d.err = ERR_EXC;
                    end
                    nxt_d.st = ST_IDLE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase

        if (busy && (wr_cmd || wr_data) && nxt_d.err == ERR_NONE) begin
            nxt_d.err = ERR_BUSY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, err: ERR_NONE, kind: KIND_CSR, idx: '0,
                       wr: 1'b0, post: 1'b0, hart: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        bus_rdata = 32'd0;
        if (bus_addr == ADDR_CS) begin
            bus_rdata[CS_BUSY_BIT]       = busy;
            bus_rdata[CS_ERR_LSB +: 3]   = cur_q.err;
            bus_rdata[3:0]               = 4'(NDATA);
        end else begin
            for (int i = 0; i < NDATA; i++) begin
                if (bus_addr == ADDR_W'(i)) begin
                    bus_rdata = words[i*32 +: 32];
                end
            end
        end
    end

    assign err_cur    = cur_q.err;
    assign hreq_valid = (cur_q.st == ST_ACCESS);
    assign hreq_write = cur_q.wr;
    assign hreq_kind  = cur_q.kind;
    assign hreq_index = cur_q.idx;
    assign hreq_hart  = cur_q.hart;
    assign hreq_wdata = words[XLEN-1:0];
    assign pb_run     = (cur_q.st == ST_PROGBUF);
endmodule

// File: rtl/abscmd_engine_chk.sv
module abscmd_engine_chk #(
    parameter int XLEN   = 64,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              hreq_valid,
    input logic [1:0]        hreq_kind,
    input logic [11:0]       hreq_index,
    input logic [XLEN-1:0]   hreq_wdata,
    input logic              hrsp_valid,
    input logic              pb_run,
    input logic              pb_done,
    input logic [2:0]        err_cur
);
    localparam logic [ADDR_W-1:0] ADDR_CS  = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] ADDR_CMD = ADDR_W'(17);

    logic busy_seen;
    assign busy_seen = hreq_valid || pb_run;

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hreq_valid && !hrsp_valid |=> hreq_valid && $stable(hreq_index)
                                      && $stable(hreq_kind) && $stable(hreq_wdata));

    p_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hreq_valid |-> hreq_kind != 2'd3 && (hreq_kind == 2'd0 || hreq_index < 12'd32));

    p_pb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pb_run && !pb_done |=> pb_run);

    p_access_pb_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hreq_valid && pb_run));

    p_busy_cmd_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_seen && bus_we && bus_addr == ADDR_CMD |=> err_cur != 3'd0);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_cur != 3'd0 && !(bus_we && bus_addr == ADDR_CS && bus_wdata[10:8] != 3'd0)
        |=> err_cur != 3'd0);

    p_no_start_on_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_cur != 3'd0 && !busy_seen |=> !hreq_valid && !pb_run);
endmodule

bind abscmd_engine abscmd_engine_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .hreq_valid (hreq_valid),
    .hreq_kind  (hreq_kind),
    .hreq_index (hreq_index),
    .hreq_wdata (hreq_wdata),
    .hrsp_valid (hrsp_valid),
    .pb_run     (pb_run),
    .pb_done    (pb_done),
    .err_cur    (err_cur)
);

// File: tb/abscmd_engine_test.sv
`timescale 1ns/1ps
module abscmd_engine_test;
    localparam int XLEN = 64;
    localparam int HW   = 10;
    localparam int AW   = 5;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            bus_we = 0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [HW-1:0]   hartsel = '0;
    logic            hart_halted = 1;
    logic            hreq_valid, hreq_write;
    logic [1:0]      hreq_kind;
    logic [11:0]     hreq_index;
    logic [HW-1:0]   hreq_hart;
    logic [XLEN-1:0] hreq_wdata;
    logic            hrsp_valid = 0, hrsp_err = 0;
    logic [XLEN-1:0] hrsp_rdata = '0;
    logic            pb_run, pb_done = 0, pb_exception = 0;

    abscmd_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hartsel(hartsel),
        .hart_halted(hart_halted), .hreq_valid(hreq_valid), .hreq_write(hreq_write),
        .hreq_kind(hreq_kind), .hreq_index(hreq_index), .hreq_hart(hreq_hart),
        .hreq_wdata(hreq_wdata), .hrsp_valid(hrsp_valid), .hrsp_err(hrsp_err),
        .hrsp_rdata(hrsp_rdata), .pb_run(pb_run), .pb_done(pb_done),
        .pb_exception(pb_exception)
    );

    always #2 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int delay_cfg = 0, dcnt = 0;
    int req_count = 0, pb_count = 0;
    bit pb_exc_cfg = 0;
    bit finished = 0;
    logic [1:0]      last_kind;
    logic [11:0]     last_idx;
    logic            last_wr;
    logic [HW-1:0]   last_hart;
    logic [XLEN-1:0] last_wdata;

    function automatic logic [XLEN-1:0] pattern(logic [1:0] k, logic [11:0] i);
        logic [31:0] lo, hi;
        lo = 32'hC0DE_0000 | {16'd0, 2'b00, k, i};
        hi = 32'h1234_0000 ^ ({20'd0, i} * 32'd3) ^ {30'd0, k};
        return {hi, lo};
    endfunction

    function automatic logic [31:0] mkcmd(bit post, bit xfer, bit wr, logic [15:0] regno);
        return {8'd0, 1'b0, 3'd3, 1'b0, post, xfer, wr, regno};
    endfunction

    // hart access model
    always @(posedge clk) begin
        hrsp_valid <= 1'b0;
        if (hreq_valid && !hrsp_valid) begin
            if (dcnt >= delay_cfg) begin
                hrsp_valid <= 1'b1;
                hrsp_rdata <= pattern(hreq_kind, hreq_index);
                hrsp_err   <= (hreq_kind == 2'd0 && hreq_index == 12'h7ff);
                req_count  = req_count + 1;
                last_kind  = hreq_kind;
                last_idx   = hreq_index;
                last_wr    = hreq_write;
                last_hart  = hreq_hart;
                last_wdata = hreq_wdata;
                dcnt       = 0;
            end else begin
                dcnt = dcnt + 1;
            end
        end
    end

    // program buffer model
    always @(posedge clk) begin
        pb_done <= 1'b0;
        if (pb_run && !pb_done) begin
            pb_done      <= 1'b1;
            pb_exception <= pb_exc_cfg;
            pb_count     = pb_count + 1;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic brd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] cs;
        for (int i = 0; i < 60; i++) begin
            brd(5'h10, cs);
            if (!cs[12]) break;
        end
    endtask

    function automatic logic [2:0] errof(logic [31:0] cs);
        return cs[10:8];
    endfunction

    task automatic clear_err();
        bwr(5'h10, 32'h0000_0700);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [31:0] v, v1;
        int rc, pc;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        brd(5'h10, v);
        check("R1 cs", 64'(v), 64'h6);
        for (int i = 0; i < 6; i++) begin
            brd(AW'(i), v);
            check("R1 data zero", 64'(v), 0);
        end

        // R2 data storage
        for (int i = 0; i < 6; i++) bwr(AW'(i), 32'hA500_0000 + 32'(i));
        for (int i = 0; i < 6; i++) begin
            brd(AW'(i), v);
            check("R2 data rw", 64'(v), 64'(32'hA500_0000 + 32'(i)));
        end
        brd(5'h11, v);
        check("R2 cmd reads 0", 64'(v), 0);

        // R3/R4/R6 GPR read, busy and hart tag
        delay_cfg = 2; hartsel = 10'd5;
        rc = req_count;
        bwr(5'h11, mkcmd(0, 1, 0, 16'h1005));
        hartsel = 10'd9;
        brd(5'h10, v);
        check("R3 busy set", 64'(v[12]), 1);
        wait_idle();
        check("R3 one request", 64'(req_count - rc), 1);
        check("R3 hart tag", 64'(last_hart), 5);
        check("R4 gpr kind", 64'({last_kind, last_idx}), 64'({2'd1, 12'd5}));
        brd(5'h0, v); brd(5'h1, v1);
        check("R6 read result", {v1, v}, pattern(2'd1, 12'd5));
        brd(5'h2, v);
        check("R6 arg1 untouched", 64'(v), 64'(32'hA500_0002));

        // R6 write: value from data0/1
        bwr(5'h0, 32'h1111_2222); bwr(5'h1, 32'h3333_4444);
        bwr(5'h11, mkcmd(0, 1, 1, 16'h0345));
        wait_idle();
        check("R6 write value", last_wdata, 64'h3333_4444_1111_2222);
        check("R4 csr kind", 64'({last_wr, last_kind, last_idx}), 64'({1'b1, 2'd0, 12'h345}));

        // R4 FPR
        bwr(5'h11, mkcmd(0, 1, 0, 16'h103f));
        wait_idle();
        check("R4 fpr kind", 64'({last_kind, last_idx}), 64'({2'd2, 12'd31}));

        // R4 reserved / gap numbers
        rc = req_count;
        bwr(5'h11, mkcmd(0, 1, 0, 16'hc000));
        brd(5'h10, v);
        check("R4 reserved err", 64'(errof(v)), 2);
        check("R4 reserved no req", 64'(req_count - rc), 0);
        clear_err();
        bwr(5'h11, mkcmd(0, 1, 0, 16'h1040));
        brd(5'h10, v);
        check("R4 gap err", 64'(errof(v)), 2);
        clear_err();

        // R5 bad size, bad type
        bwr(5'h11, 32'h0020_1000 | 32'h0002_0000);
        brd(5'h10, v);
        check("R5 size err", 64'(errof(v)), 2);
        clear_err();
        bwr(5'h11, mkcmd(0, 1, 0, 16'h1000) | 32'h0100_0000);
        brd(5'h10, v);
        check("R5 type err", 64'(errof(v)), 2);
        check("R5 no req", 64'(req_count - rc), 0);
        clear_err();

        // R7 not halted
        hart_halted = 0;
        bwr(5'h11, mkcmd(0, 1, 0, 16'h1001));
        brd(5'h10, v);
        check("R7 halt err", 64'(errof(v)), 4);
        check("R7 no req", 64'(req_count - rc), 0);
        hart_halted = 1;

        // R11 sticky: command ignored
        bwr(5'h11, mkcmd(0, 1, 0, 16'h1001));
        wait_idle();
        check("R11 ignored", 64'(req_count - rc), 0);
        brd(5'h10, v);
        check("R11 sticky", 64'(errof(v)), 4);
        bwr(5'h10, 32'h0000_0400);
        brd(5'h10, v);
        check("R11 w1c", 64'(errof(v)), 0);

        // R8 post-execute after access
        pc = pb_count;
        bwr(5'h11, mkcmd(1, 1, 0, 16'h1002));
        wait_idle();
        check("R8 pb ran", 64'(pb_count - pc), 1);
        brd(5'h10, v);
        check("R8 no err", 64'(errof(v)), 0);
        // transfer 0: run without access
        rc = req_count;
        bwr(5'h11, mkcmd(1, 0, 0, 16'hffff));
        wait_idle();
        check("R8 pb only", 64'(pb_count - pc), 2);
        check("R8 no access", 64'(req_count - rc), 0);
        // exception
        pb_exc_cfg = 1;
        bwr(5'h11, mkcmd(1, 0, 0, 16'h0));
        wait_idle();
        brd(5'h10, v);
        check("R8 exception err", 64'(errof(v)), 3);
        pb_exc_cfg = 0;
        clear_err();

        // R9 access error
        bwr(5'h0, 32'hDEAD_0000);
        pc = pb_count;
        bwr(5'h11, mkcmd(1, 1, 0, 16'h07ff));
        wait_idle();
        brd(5'h10, v);
        check("R9 err 3", 64'(errof(v)), 3);
        check("R9 no pb", 64'(pb_count - pc), 0);
        brd(5'h0, v);
        check("R9 data kept", 64'(v), 64'(32'hDEAD_0000));
        clear_err();

        // R10 writes while busy
        delay_cfg = 6;
        bwr(5'h4, 32'h4444_0000);
        rc = req_count;
        bwr(5'h11, mkcmd(0, 1, 0, 16'h1003));
        bwr(5'h4, 32'hFFFF_FFFF);
        bwr(5'h11, mkcmd(0, 1, 0, 16'h1004));
        brd(5'h10, v);
        check("R10 busy err", 64'(errof(v)), 1);
        wait_idle();
        check("R10 single req", 64'(req_count - rc), 1);
        brd(5'h4, v);
        check("R10 data dropped", 64'(v), 64'(32'h4444_0000));
        brd(5'h0, v); brd(5'h1, v1);
        check("R10 result intact", {v1, v}, pattern(2'd1, 12'd3));
        clear_err();

        // random supported commands
        for (int it = 0; it < 40; it++) begin
            logic [15:0] rn;
            logic [1:0]  ek;
            logic [11:0] ei;
            bit wr;
            logic [31:0] d0, d1;
            int sel;
            sel = $urandom_range(0, 2);
            wr = 1'($urandom_range(0, 1));
            delay_cfg = $urandom_range(0, 3);
            if (sel == 0) begin
                ei = 12'($urandom_range(0, 4095));
                if (ei == 12'h7ff) ei = 12'h7fe;
                rn = {4'h0, ei}; ek = 2'd0;
            end else begin
                ei = 12'($urandom_range(0, 31));
                rn = (sel == 1) ? 16'h1000 + 16'(ei) : 16'h1020 + 16'(ei);
                ek = 2'(sel);
            end
            d0 = $urandom; d1 = $urandom;
            bwr(5'h0, d0); bwr(5'h1, d1);
            bwr(5'h11, mkcmd(0, 1, wr, rn));
            wait_idle();
            check("R4 random decode", 64'({last_wr, last_kind, last_idx}), 64'({wr, ek, ei}));
            if (wr) begin
                check("R6 random write", last_wdata, {d1, d0});
            end else begin
                brd(5'h0, v); brd(5'h1, v1);
                check("R6 random read", {v1, v}, pattern(ek, ei));
            end
        end
        brd(5'h10, v);
        check("R3 random end idle", 64'(v), 64'h6);

        finished = 1;
        summary();
    end
endmodule